// File: doc/BRIEF.md
# System Control Register Block

A word-addressed register block that sits on a simple 32-bit register bus with a byte address, read and write strobes, write data and combinational read data. It holds two identification words and two free-running tick counters that advance at fixed fractions of the core clock, standing in for a 24 MHz and a 100 MHz timebase. It also has a general flags register with a separate clear alias, a 16-bit lock word, and six constant configuration words for oscillators and the display. Only the low 0xD4 bytes are decoded. Every other address reads zero, and writes to it do nothing.

A small bridge lets software reach a set of attached configuration devices. Software first loads a shared data register. It then writes a control word that carries a start flag, a direction flag and a 30-bit target key. If the key matches an attached device, the bridge drives that device's select line for the single cycle of the bus write. A write request sends the data register to the device. A read request captures the device's read data into the data register. Requests to unknown keys are dropped. The status word always reports completion, and the control word always reads as not busy.

Top module: `sysctl_regs`

## Requirements
- R1: While reset is held and after reset, flags, lock, configuration data and both tick counters read zero.
- R2: The identification words read as their parameter values. The display word reads 0x00001F00. The oscillator words at 0x54, 0x58, 0x5C, 0x60 and 0x64 read 0x00012C5C, 0x00002CC0, 0x00002C75, 0x00020211 and 0x00002C75. Writes to these offsets and to the reset-control offset 0x1C change nothing.
- R3: Any undecoded offset, including every offset at or above 0xD4, reads zero, and writing it changes no readable register.
- R4: The slow counter at 0x08 advances by exactly 24, and the fast counter at 0x0C by exactly 100, in any 125 consecutive clocks. Each step between consecutive clocks is 0 or 1.
- R5: A write to flags (0x10) loads all 32 bits. A write to the clear alias (0x14) sets flags to zero, whatever the data.
- R6: A write to lock (0x18) keeps only write-data bits 15:0, and the lock word reads them zero-extended.
- R7: The configuration status word (0xA8) always reads 1, and the configuration control word (0xA4) always reads 0.
- R8: A write to control with bit 31 (start) clear asserts no device select and changes no device.
- R9: A write to control with start set and bit 30 set selects the one device whose key equals bits 29:0 (controller 29:26, function 25:20, site 19:18, position 17:12, device 11:0). In that same cycle it asserts the device write enable and drives the data register (0xA0) on the device write data.
- R10: With start set and bit 30 clear, a matching device's read data is loaded into the data register, and the new value is readable from the next cycle.
- R11: With start set and a key that matches no device, no select is asserted and the data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the word access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| cfg_sel | output | DEV_N | One-hot device select, valid for one cycle |
| cfg_we | output | 1 | Device write enable |
| cfg_wdata | output | 32 | Data sent to the selected device |
| cfg_rdata | input | DEV_N*32 | Read data from each device, device 0 in the low word |

## Verification
The tick counters carry on their own schedule, so a carry can land in the same cycle as a bus read of that counter. The bench reads each counter on every clock across a full 125-cycle period, so the read meets the carry in every phase. It requires each consecutive difference to be 0 or 1 and the whole span to equal the expected count. A second overlap is the read-direction bridge request: it loads the data register in the cycle of the control write, and the bench reads the data register on the very next cycle to confirm that the captured value is already visible.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned KEY_W = 30;

  localparam logic [7:0] OFF_ID0      = 8'h00;
  localparam logic [7:0] OFF_ID1      = 8'h04;
  localparam logic [7:0] OFF_CNT_SLOW = 8'h08;
  localparam logic [7:0] OFF_CNT_FAST = 8'h0C;
  localparam logic [7:0] OFF_FLAGS    = 8'h10;
  localparam logic [7:0] OFF_FLAGCLR  = 8'h14;
  localparam logic [7:0] OFF_LOCK     = 8'h18;
  localparam logic [7:0] OFF_RSTCTL   = 8'h1C;
  localparam logic [7:0] OFF_DISP     = 8'h50;
  localparam logic [7:0] OFF_OSC0     = 8'h54;
  localparam logic [7:0] OFF_OSC1     = 8'h58;
  localparam logic [7:0] OFF_OSC2     = 8'h5C;
  localparam logic [7:0] OFF_OSC3     = 8'h60;
  localparam logic [7:0] OFF_OSC4     = 8'h64;
  localparam logic [7:0] OFF_CFGDATA  = 8'hA0;
  localparam logic [7:0] OFF_CFGCTRL  = 8'hA4;
  localparam logic [7:0] OFF_CFGSTAT  = 8'hA8;
  localparam logic [7:0] WINDOW_END   = 8'hD4;

  localparam logic [31:0] VAL_DISP = 32'h0000_1F00;
  localparam logic [31:0] VAL_OSC0 = 32'h0001_2C5C;
  localparam logic [31:0] VAL_OSC1 = 32'h0000_2CC0;
  localparam logic [31:0] VAL_OSC2 = 32'h0000_2C75;
  localparam logic [31:0] VAL_OSC3 = 32'h0002_0211;
  localparam logic [31:0] VAL_OSC4 = 32'h0000_2C75;

  localparam int unsigned BIT_START = 31;
  localparam int unsigned BIT_DIRWR = 30;

  typedef struct packed {
    logic             start;
    logic             dir_wr;
    logic [KEY_W-1:0] key;
  } cfg_req_t;
endpackage

// File: rtl/sysctl_tick_counter.sv
module sysctl_tick_counter #(
  parameter int unsigned CLK_KHZ  = 125000,
  parameter int unsigned RATE_KHZ = 24000,
  parameter int unsigned CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned ACC_W = $clog2(CLK_KHZ) + 2;
  localparam logic [ACC_W-1:0] RATE_V = ACC_W'(RATE_KHZ);
  localparam logic [ACC_W-1:0] CLK_V  = ACC_W'(CLK_KHZ);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] acc_sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             carry;

  always_comb begin
    acc_sum = acc_q + RATE_V;
    carry   = (acc_sum >= CLK_V);
    acc_d   = carry ? (acc_sum - CLK_V) : acc_sum;
    cnt_d   = carry ? (cnt_q + CNT_W'(1)) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/sysctl_cfg_bridge.sv
module sysctl_cfg_bridge
  import sysctl_pkg::*;
#(
  parameter int unsigned        DEV_N    = 3,
  parameter logic [DEV_N*KEY_W-1:0] DEV_KEYS = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_wr_en,
  input  logic               ctrl_wr_en,
  input  logic [31:0]        wdata,
  output logic [31:0]        data_q,
  output logic [DEV_N-1:0]   cfg_sel,
  output logic               cfg_we,
  output logic [31:0]        cfg_wdata,
  input  logic [DEV_N*32-1:0] cfg_rdata
);
  localparam int unsigned IDX_W = (DEV_N > 1) ? $clog2(DEV_N) : 1;

  cfg_req_t         req;
  logic [DEV_N-1:0] match;
  logic [DEV_N-1:0] first_hit;
  logic [IDX_W-1:0] hit_idx;
  logic             any_hit;
  logic [31:0]      rd_word;
  logic [31:0]      data_d;

  assign req = cfg_req_t'(wdata);

  for (genvar g = 0; g < DEV_N; g++) begin : g_match
    assign match[g] = (req.key == DEV_KEYS[g*KEY_W +: KEY_W]);
  end

  always_comb begin
    first_hit = '0;
    hit_idx   = '0;
    any_hit   = 1'b0;
    for (int i = 0; i < DEV_N; i++) begin
      if (match[i] && !any_hit) begin
        first_hit[i] = 1'b1;
        hit_idx      = IDX_W'(i);
        any_hit      = 1'b1;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < DEV_N; i++) begin
      if (hit_idx == IDX_W'(i)) rd_word = cfg_rdata[i*32 +: 32];
    end
  end

  assign cfg_sel   = (ctrl_wr_en && req.start) ? first_hit : '0;
  assign cfg_we    = ctrl_wr_en && req.start && req.dir_wr && any_hit;
  assign cfg_wdata = data_q;

  always_comb begin
    data_d = data_q;
    if (data_wr_en)
      data_d = wdata;
    else if (ctrl_wr_en && req.start && !req.dir_wr && any_hit)
      data_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned            DEV_N    = 3,
  parameter logic [DEV_N*KEY_W-1:0] DEV_KEYS = {30'h0830_1003, 30'h0420_2005, 30'h0410_0000},
  parameter logic [31:0]            ID0_VAL  = 32'h5157_0001,
  parameter logic [31:0]            ID1_VAL  = 32'h5157_0002,
  parameter int unsigned            CLK_KHZ  = 125000,
  parameter int unsigned            SLOW_KHZ = 24000,
  parameter int unsigned            FAST_KHZ = 100000,
  parameter int unsigned            CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [DEV_N-1:0]    cfg_sel,
  output logic                cfg_we,
  output logic [31:0]         cfg_wdata,
  input  logic [DEV_N*32-1:0] cfg_rdata
);
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  logic        in_win;
  logic        wr_flags, wr_clr, wr_lock, wr_data, wr_ctrl;
  logic [31:0] flags_q, flags_d;
  logic [15:0] lock_q, lock_d;
  logic [31:0] cfg_data_q;
  logic [CNT_W-1:0] cnt_slow, cnt_fast;

  assign in_win   = (bus_addr < WINDOW_END);
  assign wr_flags = bus_wr && in_win && (bus_addr == OFF_FLAGS);
  assign wr_clr   = bus_wr && in_win && (bus_addr == OFF_FLAGCLR);
  assign wr_lock  = bus_wr && in_win && (bus_addr == OFF_LOCK);
  assign wr_data  = bus_wr && in_win && (bus_addr == OFF_CFGDATA);
  assign wr_ctrl  = bus_wr && in_win && (bus_addr == OFF_CFGCTRL);

  sysctl_tick_counter #(.CLK_KHZ(CLK_KHZ), .RATE_KHZ(SLOW_KHZ), .CNT_W(CNT_W)) u_cnt_slow (
    .clk(clk), .rst_n(rst_int_n), .count(cnt_slow)
  );
  sysctl_tick_counter #(.CLK_KHZ(CLK_KHZ), .RATE_KHZ(FAST_KHZ), .CNT_W(CNT_W)) u_cnt_fast (
    .clk(clk), .rst_n(rst_int_n), .count(cnt_fast)
  );

  sysctl_cfg_bridge #(.DEV_N(DEV_N), .DEV_KEYS(DEV_KEYS)) u_bridge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .data_wr_en(wr_data),
    .ctrl_wr_en(wr_ctrl),
    .wdata     (bus_wdata),
    .data_q    (cfg_data_q),
    .cfg_sel   (cfg_sel),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata)
  );

  always_comb begin
    flags_d = flags_q;
    if (wr_clr)        flags_d = '0;
    else if (wr_flags) flags_d = bus_wdata;
    lock_d = wr_lock ? bus_wdata[15:0] : lock_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flags_q <= '0;
      lock_q  <= '0;
    end else begin
      flags_q <= flags_d;
      lock_q  <= lock_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && in_win) begin
      unique case (bus_addr)
        OFF_ID0:      bus_rdata = ID0_VAL;
        OFF_ID1:      bus_rdata = ID1_VAL;
        OFF_CNT_SLOW: bus_rdata = 32'(cnt_slow);
        OFF_CNT_FAST: bus_rdata = 32'(cnt_fast);
        OFF_FLAGS:    bus_rdata = flags_q;
        OFF_LOCK:     bus_rdata = {16'h0000, lock_q};
        OFF_DISP:     bus_rdata = VAL_DISP;
        OFF_OSC0:     bus_rdata = VAL_OSC0;
        OFF_OSC1:     bus_rdata = VAL_OSC1;
        OFF_OSC2:     bus_rdata = VAL_OSC2;
        OFF_OSC3:     bus_rdata = VAL_OSC3;
        OFF_OSC4:     bus_rdata = VAL_OSC4;
        OFF_CFGDATA:  bus_rdata = cfg_data_q;
        OFF_CFGCTRL:  bus_rdata = 32'h0;
        OFF_CFGSTAT:  bus_rdata = 32'h1;
        default:      bus_rdata = 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int unsigned DEV_N = 3,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [DEV_N-1:0] cfg_sel,
  input logic             cfg_we,
  input logic [31:0]      cfg_data_q,
  input logic [31:0]      flags_q,
  input logic [CNT_W-1:0] cnt_slow,
  input logic [CNT_W-1:0] cnt_fast
);
  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_sel));

  p_sel_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_sel) |-> (bus_wr && bus_addr == 8'hA4 && bus_wdata[31]));

  p_we_follows_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_sel) |-> (cfg_we == bus_wdata[30]));

  p_miss_keeps_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hA4 && !(|cfg_sel)) |=> $stable(cfg_data_q));

  p_clear_zeroes_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h14) |=> (flags_q == 32'h0));

  p_slow_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(cnt_slow - $past(cnt_slow)) <= CNT_W'(1)));

  p_fast_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(cnt_fast - $past(cnt_fast)) <= CNT_W'(1)));
endmodule

bind sysctl_regs sysctl_regs_chk #(.DEV_N(DEV_N), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cfg_sel   (cfg_sel),
  .cfg_we    (cfg_we),
  .cfg_data_q(cfg_data_q),
  .flags_q   (flags_q),
  .cnt_slow  (cnt_slow),
  .cnt_fast  (cnt_fast)
);

// File: tb/sysctl_regs_tb_top.sv
`timescale 1ns/1ps
module sysctl_regs_tb_top;
  localparam int unsigned DEV_N = 3;
  localparam logic [29:0] K0 = 30'h0410_0000;
  localparam logic [29:0] K1 = 30'h0420_2005;
  localparam logic [29:0] K2 = 30'h0830_1003;
  localparam logic [31:0] ID0 = 32'h5157_0001;
  localparam logic [31:0] ID1 = 32'h5157_0002;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [DEV_N-1:0]  cfg_sel;
  logic              cfg_we;
  logic [31:0]       cfg_wdata;
  logic [DEV_N*32-1:0] cfg_rdata;

  always #4 clk = ~clk;

  sysctl_regs #(.DEV_N(DEV_N), .DEV_KEYS({K2, K1, K0}), .ID0_VAL(ID0), .ID1_VAL(ID1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  logic [31:0] dev_mem [DEV_N];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEV_N; i++) dev_mem[i] <= 32'hD000_0000 + 32'(i * 'h11);
    end else begin
      for (int i = 0; i < DEV_N; i++)
        if (cfg_sel[i] && cfg_we) dev_mem[i] <= cfg_wdata;
    end
  end
  for (genvar g = 0; g < DEV_N; g++) begin : g_rd
    assign cfg_rdata[g*32 +: 32] = dev_mem[g];
  end

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] sh_flags = '0;
  logic [31:0] sh_lock = '0;
  logic [31:0] sh_data = '0;
  logic [DEV_N-1:0] seen_sel;
  logic seen_we;
  logic [31:0] seen_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    #1;
    seen_sel = cfg_sel; seen_we = cfg_we; seen_wdata = cfg_wdata;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    case (a)
      8'h00: return ID0;
      8'h04: return ID1;
      8'h10: return sh_flags;
      8'h18: return sh_lock;
      8'h50: return 32'h0000_1F00;
      8'h54: return 32'h0001_2C5C;
      8'h58: return 32'h0000_2CC0;
      8'h5C: return 32'h0000_2C75;
      8'h60: return 32'h0002_0211;
      8'h64: return 32'h0000_2C75;
      8'hA0: return sh_data;
      8'hA8: return 32'h1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit fixed_or_dead(input logic [7:0] a);
    return !(a inside {8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'hA0, 8'hA4});
  endfunction

  task automatic sweep(input string tag);
    logic [31:0] v;
    for (int a = 0; a < 256; a += 4) begin
      if (a == 8 || a == 12) continue;
      bus_read(8'(a), v);
      check(tag, v, exp_word(8'(a)));
    end
  endtask

  task automatic count_sweep(input logic [7:0] a, input int unsigned per125, input string tag);
    logic [31:0] v, first, prev;
    bit step_ok = 1'b1;
    bus_read(a, first);
    prev = first;
    for (int i = 0; i < 125; i++) begin
      bus_read(a, v);
      if ((v - prev) > 32'd1) step_ok = 1'b0;
      prev = v;
    end
    check({tag, " step"}, 32'(step_ok), 32'd1);
    check({tag, " span"}, v - first, 32'(per125));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    // R1: state during reset
    repeat (3) @(negedge clk);
    bus_read(8'h08, v); check("R1 slow counter in reset", v, 32'h0);
    bus_read(8'h0C, v); check("R1 fast counter in reset", v, 32'h0);
    bus_read(8'h10, v); check("R1 flags in reset", v, 32'h0);
    bus_read(8'h18, v); check("R1 lock in reset", v, 32'h0);
    bus_read(8'hA0, v); check("R1 data in reset", v, 32'h0);
    idle();
    rst_n = 1'b1;
    repeat (4) idle();

    // R2 R3 R7: full sweep of the address space
    sweep("R2/R3/R7 sweep after reset");
    bus_read(8'hA4, v); check("R7 control reads 0", v, 32'h0);
    bus_read(8'hA8, v); check("R7 status reads 1", v, 32'h1);

    // R2 R3: writes to fixed, reset-control and undecoded offsets
    for (int a = 0; a < 256; a += 4)
      if (fixed_or_dead(8'(a))) bus_write(8'(a), 32'hFFFF_FFFF);
    idle();
    sweep("R2/R3 sweep after ignored writes");

    // R5 flags
    bus_write(8'h10, 32'hA5C3_0F81); sh_flags = 32'hA5C3_0F81;
    bus_read(8'h10, v); check("R5 flags full load", v, sh_flags);
    bus_write(8'h14, 32'h0000_0000); sh_flags = '0;
    bus_read(8'h10, v); check("R5 clear with zero data", v, 32'h0);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h14, 32'h1234_5678);
    bus_read(8'h10, v); check("R5 clear with nonzero data", v, 32'h0);

    // R6 lock
    bus_write(8'h18, 32'hBEEF_A55A); sh_lock = 32'h0000_A55A;
    bus_read(8'h18, v); check("R6 lock low half only", v, sh_lock);

    // R4 counters, read every cycle over a full period
    count_sweep(8'h08, 24, "R4 slow counter");
    count_sweep(8'h0C, 100, "R4 fast counter");

    // R9 write request to device 1
    bus_write(8'hA0, 32'h1234_5678); sh_data = 32'h1234_5678;
    bus_write(8'hA4, {2'b11, K1});
    check("R9 select one-hot device 1", 32'(seen_sel), 32'b010);
    check("R9 write enable", 32'(seen_we), 32'd1);
    check("R9 write data", seen_wdata, 32'h1234_5678);
    idle();
    check("R9 device 1 updated", dev_mem[1], 32'h1234_5678);
    check("R9 device 0 untouched", dev_mem[0], 32'hD000_0000);

    // R8 start clear
    bus_write(8'hA0, 32'hCAFE_0001); sh_data = 32'hCAFE_0001;
    bus_write(8'hA4, {2'b01, K0});
    check("R8 no select without start", 32'(seen_sel), 32'h0);
    idle();
    check("R8 device 0 unchanged", dev_mem[0], 32'hD000_0000);
    bus_read(8'hA4, v); check("R7 control still reads 0", v, 32'h0);

    // R10 read request from device 2, read back the very next cycle
    bus_write(8'hA4, {2'b10, K2});
    check("R10 select device 2", 32'(seen_sel), 32'b100);
    check("R10 no write enable", 32'(seen_we), 32'd0);
    sh_data = 32'hD000_0022;
    bus_read(8'hA0, v); check("R10 data captured next cycle", v, sh_data);

    // R11 unmatched keys, both directions
    bus_write(8'hA4, {2'b10, 30'h0000_0001});
    check("R11 no select on miss (read)", 32'(seen_sel), 32'h0);
    bus_read(8'hA0, v); check("R11 data kept on miss", v, sh_data);
    bus_write(8'hA4, {2'b11, 30'h3FFF_FFFF});
    check("R11 no select on miss (write)", 32'(seen_sel), 32'h0);
    idle();
    check("R11 device 2 unchanged", dev_mem[2], 32'hD000_0022);

    // R1: registers return to zero after a second reset
    rst_n = 1'b0;
    repeat (2) idle();
    sh_flags = '0; sh_lock = '0; sh_data = '0;
    bus_read(8'h18, v); check("R1 lock after reset", v, 32'h0);
    bus_read(8'hA0, v); check("R1 data after reset", v, 32'h0);
    rst_n = 1'b1;
    idle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule